// File: doc/BRIEF.md
# Variable-Frequency NCO Clock-Enable Generator

This block is a numerically controlled oscillator that runs from a fixed reference clock. On every reference cycle it adds an increment to a phase accumulator that wraps. The top bit of the accumulator is the square-wave output. A single-cycle tick marks each rising edge of that square wave, and it is meant to act as the clock enable of a downstream PWM stage.

Software sets the frequency with a control word that it writes as two bytes, each with its own strobe. The upper byte is only staged. Writing the lower byte moves the staged upper byte and the new lower byte together into the active word. A control word with its top bit set is taken as a negative number, and the size of that number becomes the increment. The output frequency is the increment divided by 2^16, multiplied by the reference frequency. While the run input is low, the accumulator is held at zero.

Top module: `nco_clkgen`

## Requirements
- R1: After reset, `wave` and `tick` are low. The active word and the staged upper byte are both zero, so with no writes the accumulator stays at zero even while `run` is high.
- R2: A pulse on `wr_hi` alone only stages `wr_data` as the upper byte. The increment in use does not change until a later `wr_lo` pulse.
- R3: A pulse on `wr_lo` loads the active word with the staged upper byte in bits 15:8 and `wr_data` in bits 7:0. The new word is first added on the clock edge after the write edge. If both strobes come in the same cycle, the commit uses the upper byte that was staged before that edge.
- R4: The increment equals the active word when bit 15 of the word is 0. Otherwise it equals (2^16 − word) mod 2^16. For example, 0xF000 gives 0x1000 and 0x8000 gives 0x8000.
- R5: While `run` is high, the accumulator adds the increment on every clock edge and wraps modulo 2^16.
- R6: An edge with `run` low sets the accumulator to zero, so after that edge `wave` and `tick` are low.
- R7: `wave` is bit 15 of the accumulator.
- R8: `tick` is high for exactly the one cycle in which `wave` is 1 and was 0 in the cycle before. Two cycles in a row never both have `tick` high.
- R9: When the increment is a power of two, starting from zero, `wave` is high for exactly half of every 2^16/increment cycles, with one tick per period. For example, 0x1000 gives 32 high cycles and 4 ticks in 64 cycles, and 0x8000 gives 32 ticks in 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: accumulate; low: hold accumulator at zero |
| wr_hi | input | 1 | Strobe that stages `wr_data` as the upper control byte |
| wr_lo | input | 1 | Strobe that commits the staged upper byte with `wr_data` as the lower byte |
| wr_data | input | 8 | Byte written by either strobe |
| wave | output | 1 | Square wave, accumulator MSB |
| tick | output | 1 | One-cycle pulse on each rising edge of `wave` |

## Verification
The assertions assume that the strobes and `run` are sampled cleanly on the reference clock. The checker does not need the two strobes to be exclusive, because a pulse on the upper strobe alone is the only case it treats as a no-commit event. The stimulus changes inputs only on the falling clock edge. Random writes, which are never simultaneous, are mixed with long stretches of `run` high. Directed segments stop the accumulator first and then count `wave` and `tick` from a known zero phase, which makes the duty-cycle and folded-increment checks exact.

// File: rtl/nco_pkg.sv
package nco_pkg;
  parameter int unsigned NCO_BYTE_W = 8;
  parameter int unsigned NCO_WORD_W = 2 * NCO_BYTE_W;
  typedef logic [NCO_WORD_W-1:0] nco_word_t;
endpackage

// File: rtl/nco_word_reg.sv
module nco_word_reg #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] hi_stage_q;
  logic [WORD_W-1:0] word_q;

  // Upper byte waits here until a lower-byte write commits it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
    end else if (wr_hi) begin
      hi_stage_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_lo) begin
      word_q <= {hi_stage_q, wr_data};
    end
  end

  assign word = word_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] incr,
  output logic [WORD_W-1:0] acc
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] neg_word;

  // Words with the sign bit set are folded to their magnitude.
  assign neg_word = ~word + WORD_W'(1);
  assign incr     = word[WORD_W-1] ? neg_word : word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (!run) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_q + incr;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/nco_rise_tick.sv
module nco_rise_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic tick
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d <= 1'b0;
    end else begin
      level_d <= level;
    end
  end

  assign tick = level & ~level_d;
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int unsigned BYTE_W = nco_pkg::NCO_BYTE_W,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wave,
  output logic              tick
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] incr;
  logic [WORD_W-1:0] acc_q;

  nco_word_reg #(.BYTE_W(BYTE_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .word    (word_q)
  );

  nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .word  (word_q),
    .incr  (incr),
    .acc   (acc_q)
  );

  assign wave = acc_q[WORD_W-1];

  nco_rise_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .level (wave),
    .tick  (tick)
  );
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              wr_hi,
  input logic              wr_lo,
  input logic              wave,
  input logic              tick,
  input logic [WORD_W-1:0] word,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] incr
);
  AST_HI_ONLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(word)); // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (acc == WORD_W'($past(acc) + $past(incr)))); // R5
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc == '0)); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!wave && !tick)); // R6
  AST_WAVE_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    wave == acc[WORD_W-1]); // R7
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (wave && !$past(wave))); // R8
  AST_TICK_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R8
endmodule

bind nco_clkgen nco_clkgen_chk #(.WORD_W(WORD_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run),
  .wr_hi (wr_hi),
  .wr_lo (wr_lo),
  .wave  (wave),
  .tick  (tick),
  .word  (word_q),
  .acc   (acc_q),
  .incr  (incr)
);

// File: tb/nco_clkgen_tb_top.sv
`timescale 1ns/1ps
module nco_clkgen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wave;
  logic       tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_stage = '0;
  logic [15:0] m_word = '0;
  logic [15:0] m_acc = '0;
  logic        m_msb = 1'b0;
  logic        s_wave;
  logic        s_tick;

  always #10 clk = ~clk;

  nco_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .wave(wave), .tick(tick)
  );

  function automatic logic [15:0] fold(input logic [15:0] w);
    return w[15] ? 16'(17'h10000 - {1'b0, w}) : w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic h, input logic l, input logic [7:0] d);
    logic ew;
    logic et;
    @(negedge clk);
    s_wave = wave;
    s_tick = tick;
    ew = m_acc[15];
    et = m_acc[15] & ~m_msb;
    check(s_wave == ew, "R7 wave", int'(s_wave), int'(ew));
    check(s_tick == et, "R8 tick", int'(s_tick), int'(et));
    run = r; wr_hi = h; wr_lo = l; wr_data = d;
    m_msb = m_acc[15];
    m_acc = r ? 16'(m_acc + fold(m_word)) : 16'h0;
    if (l) m_word = {m_stage, d};
    if (h) m_stage = d;
  endtask

  task automatic load(input logic [15:0] w);
    step(1'b0, 1'b1, 1'b0, w[15:8]);
    step(1'b0, 1'b0, 1'b1, w[7:0]);
    step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic count64(output int hi_n, output int tk_n);
    hi_n = 0; tk_n = 0;
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00);
      hi_n += int'(s_wave);
      tk_n += int'(s_tick);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hi_n;
    int tk_n;
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    check(wave == 1'b0, "R1 reset wave", int'(wave), 0);
    check(tick == 1'b0, "R1 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    // R1: no word written, running keeps everything low
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
    check(wave == 1'b0, "R1 idle word", int'(wave), 0);

    // R9: power-of-two word gives 50% duty
    load(16'h1000);
    count64(hi_n, tk_n);
    check(hi_n == 32, "R9 duty 0x1000", hi_n, 32);
    check(tk_n == 4, "R9 ticks 0x1000", tk_n, 4);

    // R2: upper byte alone does not change the rate
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b0, 8'h40);
    count64(hi_n, tk_n);
    check(tk_n == 4, "R2 hi only ticks", tk_n, 4);
    check(hi_n == 32, "R2 hi only duty", hi_n, 32);

    // R3: lower write commits staged 0x40 -> word 0x4000, 16 ticks
    step(1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    count64(hi_n, tk_n);
    check(tk_n == 16, "R3 commit ticks", tk_n, 16);

    // R4: 0xF000 folds to 0x1000
    load(16'hF000);
    count64(hi_n, tk_n);
    check(tk_n == 4, "R4 folded ticks", tk_n, 4);
    check(hi_n == 32, "R4 folded duty", hi_n, 32);

    // R5: 0x8000 wraps every other cycle
    load(16'h8000);
    count64(hi_n, tk_n);
    check(tk_n == 32, "R5 wrap ticks", tk_n, 32);
    check(hi_n == 32, "R5 wrap duty", hi_n, 32);

    // R6: stop forces wave low after the edge
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(s_wave == 1'b0, "R6 stopped wave", int'(s_wave), 0);
    check(s_tick == 1'b0, "R6 stopped tick", int'(s_tick), 0);

    // random phase, checked against the bench model (R3 R5 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic r;
      logic h;
      logic l;
      sel = int'($urandom_range(0, 9));
      r = (sel != 0);
      h = ($urandom_range(0, 19) == 0);
      l = !h && ($urandom_range(0, 19) == 0);
      step(r, h, l, 8'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule